// File: doc/BRIEF.md
# ADC Conversion Sequencer with Threshold-Gated Interrupt

This block controls an abstract successive-approximation conversion engine. Software programs it through a write-only register port. The block picks the analog channel, issues one-cycle start pulses to the engine and collects each 10-bit result into a per-channel result register. Software can read any result register combinationally through a channel-indexed read port.

Channels run in select order (one fixed channel) or in scan order (channel 0 up to the selected channel). Either order runs one-shot or continuously. When a conversion finishes, the upper eight bits of the result are compared with a programmable threshold. The conversion-end interrupt fires only when the chosen comparison holds. The result is stored whether or not the comparison holds, so the interrupt works as a level watchdog, for example to detect a supply that falls below a limit, without losing data.

Register map, at address `reg_addr_i`:
- 0: control. bit0 is enable, bit1 is scan, bit2 is one-shot, bit3 is compare-enable and bit4 is compare-less-than.
- 1: channel select, in the low bits.
- 2: threshold, in bits 7:0.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset `irq_o` and `conv_start_o` are low, and every result register reads 0.
- R2: With compare-enable (control bit3) at 0, `irq_o` pulses in the cycle after every accepted `conv_done_i`.
- R3: With compare-enable 1 and compare-less-than (bit4) 0, `irq_o` pulses only if result[9:2] >= threshold (address 2).
- R4: With compare-enable 1 and compare-less-than 1, `irq_o` pulses only if result[9:2] < threshold.
- R5: Each accepted conversion result is written to the result register of its channel, whether or not an interrupt is raised.
- R6: A write to address 0 with bit0 = 1 while the sequencer is idle starts a sequence.
- R7: In continuous select mode (bit1 = 0, bit2 = 0), the channel at address 1 is converted repeatedly. Each new start pulse is issued in the cycle right after the previous done is accepted.
- R8: In scan mode (bit1 = 1), channels are converted in ascending order from 0 up to the selected channel. In continuous operation the order then wraps to 0.
- R9: In one-shot select mode (bit1 = 0, bit2 = 1) exactly one conversion runs, and one-shot scan stops after the selected channel. No start follows until a new write to address 0 with bit0 = 1.
- R10: A write to address 0 with bit0 = 0 aborts a running sequence. The in-flight result is not stored, no interrupt is raised and no further start is issued.
- R11: `irq_o` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| rd_ch_i | input | 3 | Result read channel |
| rd_data_o | output | 10 | Result register of rd_ch_i |
| conv_start_o | output | 1 | One-cycle start pulse to the engine |
| conv_ch_o | output | 3 | Channel for the engine |
| conv_done_i | input | 1 | Engine completion pulse |
| conv_data_i | input | 10 | Engine result, valid with conv_done_i |
| irq_o | output | 1 | Threshold-gated conversion-end interrupt |

## Verification
The hardest case to reach is an abort that lands while a conversion is in flight. The engine later delivers a done pulse that the idle sequencer must ignore, and the previous value in the result register must survive. The bench first fills the channel with a known value. It then starts a new one-shot conversion with a different engine value and clears enable two cycles later, inside the wait window. Finally it reads the register back and counts interrupts before it restarts. A sweep over compare modes, threshold edges and result bytes at 0, 1, 127, 128, 254 and 255 covers both sides of each comparison.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned A_CTRL  = 0;
  localparam int unsigned A_CHSEL = 1;
  localparam int unsigned A_THR   = 2;

  localparam int unsigned B_EN   = 0;
  localparam int unsigned B_SCAN = 1;
  localparam int unsigned B_ONCE = 2;
  localparam int unsigned B_CMP  = 3;
  localparam int unsigned B_LT   = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_WAIT} seq_st_e;

  typedef struct packed {
    logic en;
    logic scan;
    logic once;
    logic cmp_en;
    logic cmp_lt;
  } cfg_t;
endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CH_W   = 3,
  parameter int unsigned CMP_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output cfg_t              cfg_o,
  output logic [CH_W-1:0]   chsel_o,
  output logic [CMP_W-1:0]  thr_o,
  output logic              start_o,
  output logic              start_scan_o,
  output logic              abort_o
);
  logic ctrl_wr;

  assign ctrl_wr      = we_i && (addr_i == ADDR_W'(A_CTRL));
  assign start_o      = ctrl_wr && wdata_i[B_EN];
  assign abort_o      = ctrl_wr && !wdata_i[B_EN];
  assign start_scan_o = wdata_i[B_SCAN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o   <= '0;
      chsel_o <= '0;
      thr_o   <= '0;
    end else if (we_i) begin
      if (addr_i == ADDR_W'(A_CTRL)) begin
        cfg_o.en     <= wdata_i[B_EN];
        cfg_o.scan   <= wdata_i[B_SCAN];
        cfg_o.once   <= wdata_i[B_ONCE];
        cfg_o.cmp_en <= wdata_i[B_CMP];
        cfg_o.cmp_lt <= wdata_i[B_LT];
      end
      if (addr_i == ADDR_W'(A_CHSEL)) chsel_o <= wdata_i[CH_W-1:0];
      if (addr_i == ADDR_W'(A_THR))   thr_o   <= wdata_i[CMP_W-1:0];
    end
  end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int unsigned CH_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            scan_i,
  input  logic            once_i,
  input  logic [CH_W-1:0] chsel_i,
  input  logic            start_i,
  input  logic            start_scan_i,
  input  logic            abort_i,
  input  logic            done_i,
  output logic            conv_start_o,
  output logic [CH_W-1:0] ch_o,
  output logic            store_o,
  output logic            waiting_o
);
  seq_st_e         st_q;
  logic [CH_W-1:0] ch_q;
  logic            last_ch;

  assign conv_start_o = (st_q == ST_START);
  assign waiting_o    = (st_q == ST_WAIT);
  assign ch_o         = ch_q;
  assign store_o      = waiting_o && done_i && !abort_i;
  // scan ends at or past the select value, so lowering it mid-scan cannot run away
  assign last_ch      = (ch_q >= chsel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      ch_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q <= ST_START;
            ch_q <= start_scan_i ? '0 : chsel_i;
          end
        end
        ST_START: begin
          st_q <= (abort_i || !en_i) ? ST_IDLE : ST_WAIT;
        end
        ST_WAIT: begin
          if (abort_i || !en_i) begin
            st_q <= ST_IDLE;
          end else if (done_i) begin
            if (!scan_i) begin
              st_q <= once_i ? ST_IDLE : ST_START;
              ch_q <= chsel_i;
            end else if (last_ch) begin
              st_q <= once_i ? ST_IDLE : ST_START;
              ch_q <= '0;
            end else begin
              st_q <= ST_START;
              ch_q <= ch_q + CH_W'(1);
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_cmp.sv
module adc_seq_cmp #(
  parameter int unsigned CMP_W = 8
) (
  input  logic [CMP_W-1:0] res_hi_i,
  input  logic [CMP_W-1:0] thr_i,
  input  logic             cmp_en_i,
  input  logic             cmp_lt_i,
  output logic             hit_o
);
  logic ge;

  assign ge    = (res_hi_i >= thr_i);
  assign hit_o = !cmp_en_i || (cmp_lt_i ? !ge : ge);
endmodule

// File: rtl/adc_seq_results.sv
module adc_seq_results #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned RES_W  = 10,
  parameter int unsigned CH_W   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CH_W-1:0]  wr_ch_i,
  input  logic [RES_W-1:0] wdata_i,
  input  logic [CH_W-1:0]  rd_ch_i,
  output logic [RES_W-1:0] rd_data_o
);
  logic [RES_W-1:0] res_q [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_res
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               res_q[g] <= '0;
      else if (we_i && wr_ch_i == CH_W'(g))      res_q[g] <= wdata_i;
    end
  end

  assign rd_data_o = res_q[rd_ch_i];
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned RES_W  = 10,
  parameter int unsigned CMP_W  = 8,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      reg_we_i,
  input  logic [ADDR_W-1:0]         reg_addr_i,
  input  logic [DATA_W-1:0]         reg_wdata_i,
  input  logic [$clog2(NUM_CH)-1:0] rd_ch_i,
  output logic [RES_W-1:0]          rd_data_o,
  output logic                      conv_start_o,
  output logic [$clog2(NUM_CH)-1:0] conv_ch_o,
  input  logic                      conv_done_i,
  input  logic [RES_W-1:0]          conv_data_i,
  output logic                      irq_o
);
  localparam int unsigned CH_W = $clog2(NUM_CH);

  cfg_t             cfg;
  logic [CH_W-1:0]  chsel;
  logic [CMP_W-1:0] thr;
  logic             start_p, start_scan, abort_p;
  logic             store, waiting, hit;
  logic             irq_q;

  adc_seq_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CH_W(CH_W), .CMP_W(CMP_W)
  ) i_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (reg_we_i),
    .addr_i       (reg_addr_i),
    .wdata_i      (reg_wdata_i),
    .cfg_o        (cfg),
    .chsel_o      (chsel),
    .thr_o        (thr),
    .start_o      (start_p),
    .start_scan_o (start_scan),
    .abort_o      (abort_p)
  );

  adc_seq_fsm #(.CH_W(CH_W)) i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (cfg.en),
    .scan_i       (cfg.scan),
    .once_i       (cfg.once),
    .chsel_i      (chsel),
    .start_i      (start_p),
    .start_scan_i (start_scan),
    .abort_i      (abort_p),
    .done_i       (conv_done_i),
    .conv_start_o (conv_start_o),
    .ch_o         (conv_ch_o),
    .store_o      (store),
    .waiting_o    (waiting)
  );

  adc_seq_cmp #(.CMP_W(CMP_W)) i_cmp (
    .res_hi_i (conv_data_i[RES_W-1 -: CMP_W]),
    .thr_i    (thr),
    .cmp_en_i (cfg.cmp_en),
    .cmp_lt_i (cfg.cmp_lt),
    .hit_o    (hit)
  );

  adc_seq_results #(.NUM_CH(NUM_CH), .RES_W(RES_W), .CH_W(CH_W)) i_res (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (store),
    .wr_ch_i   (conv_ch_o),
    .wdata_i   (conv_data_i),
    .rd_ch_i   (rd_ch_i),
    .rd_data_o (rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= store && hit;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int unsigned CH_W   = 3,
  parameter int unsigned CMP_W  = 8,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              conv_start_o,
  input logic [CH_W-1:0]   conv_ch_o,
  input logic              conv_done_i,
  input logic [CMP_W-1:0]  res_hi,
  input logic              irq_o,
  input logic              waiting,
  input logic              cmp_en,
  input logic              cmp_lt,
  input logic              scan,
  input logic              once,
  input logic [CH_W-1:0]   chsel,
  input logic [CMP_W-1:0]  thr
);
  logic accept, abort_wr;

  assign accept   = waiting && conv_done_i && !reg_we_i;
  assign abort_wr = reg_we_i && (reg_addr_i == '0) && !reg_wdata_i[0];

  p_irq_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  p_irq_cause_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(waiting && conv_done_i));

  p_nocmp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !cmp_en) |=> irq_o);

  p_ge_pass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && cmp_en && !cmp_lt && res_hi >= thr) |=> irq_o);

  p_ge_block_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && cmp_en && !cmp_lt && res_hi < thr) |=> !irq_o);

  p_lt_pass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && cmp_en && cmp_lt && res_hi < thr) |=> irq_o);

  p_lt_block_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && cmp_en && cmp_lt && res_hi >= thr) |=> !irq_o);

  p_back_to_back_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !scan && !once) |=> (conv_start_o && conv_ch_o == $past(chsel)));

  p_abort_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_wr |=> (!irq_o && !conv_start_o));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
  .CH_W(CH_W), .CMP_W(CMP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_we_i     (reg_we_i),
  .reg_addr_i   (reg_addr_i),
  .reg_wdata_i  (reg_wdata_i),
  .conv_start_o (conv_start_o),
  .conv_ch_o    (conv_ch_o),
  .conv_done_i  (conv_done_i),
  .res_hi       (conv_data_i[RES_W-1 -: CMP_W]),
  .irq_o        (irq_o),
  .waiting      (waiting),
  .cmp_en       (cfg.cmp_en),
  .cmp_lt       (cfg.cmp_lt),
  .scan         (cfg.scan),
  .once         (cfg.once),
  .chsel        (chsel),
  .thr          (thr)
);

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
  localparam int CLK_P = 10;
  localparam int LAT   = 3;
  localparam int NCH   = 8;
  localparam int EN = 1, SCAN = 2, ONCE = 4, CMP = 8, LT = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [2:0] rd_ch = '0;
  logic [9:0] rd_data;
  logic       conv_start;
  logic [2:0] conv_ch;
  logic       conv_done = 1'b0;
  logic [9:0] conv_data = '0;
  logic       irq;

  int n_vec = 0;
  int n_err = 0;

  always #(CLK_P/2) clk = ~clk;

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .rd_ch_i(rd_ch), .rd_data_o(rd_data),
    .conv_start_o(conv_start), .conv_ch_o(conv_ch), .conv_done_i(conv_done),
    .conv_data_i(conv_data), .irq_o(irq)
  );

  // engine model: done visible LAT+1 cycles after the start pulse is sampled
  logic [9:0] eng_val [NCH];
  int         eng_cnt = 0;
  logic [2:0] eng_ch = '0;
  always @(posedge clk) begin
    if (conv_start) begin
      eng_cnt   <= LAT;
      eng_ch    <= conv_ch;
      conv_done <= 1'b0;
    end else if (eng_cnt != 0) begin
      eng_cnt   <= eng_cnt - 1;
      conv_done <= (eng_cnt == 1);
      if (eng_cnt == 1) conv_data <= eng_val[eng_ch];
    end else begin
      conv_done <= 1'b0;
    end
  end

  // monitor
  int cyc = 0, n_start = 0, n_irq = 0;
  int log_ch [256];
  int log_t  [256];
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (conv_start) begin
      if (n_start < 256) begin
        log_ch[n_start] <= int'(conv_ch);
        log_t[n_start]  <= cyc;
      end
      n_start <= n_start + 1;
    end
    if (irq) n_irq <= n_irq + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a[1:0]; reg_wdata = d[7:0];
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int ch, output int v);
    rd_ch = ch[2:0];
    #1 v = int'(rd_data);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_err++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    int his[6] = '{0, 1, 127, 128, 254, 255};
    int s0, i0, v, ns, exp_irq;
    for (int c = 0; c < NCH; c++) eng_val[c] = '0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);

    // R1 reset state
    chk("R1 irq", int'(irq), 0);
    chk("R1 start", n_start, 0);
    for (int c = 0; c < NCH; c++) begin
      rd(c, v);
      chk("R1 result", v, 0);
    end

    // R2 R3 R4 R5 R6 R11: one-shot select sweep over compare modes
    for (int m = 0; m < 3; m++) begin
      for (int ti = 0; ti < 6; ti++) begin
        for (int vi = 0; vi < 6; vi++) begin
          int ch, val, ctrl;
          ch  = (ti * 6 + vi + m) % NCH;
          val = (his[vi] << 2) | ((vi + ti) % 4);
          eng_val[ch] = val[9:0];
          wr(2, his[ti]);
          wr(1, ch);
          s0 = n_start; i0 = n_irq;
          ctrl = EN | ONCE | (m > 0 ? CMP : 0) | (m == 2 ? LT : 0);
          wr(0, ctrl);
          wait_cyc(12);
          if (m == 0)      exp_irq = 1;
          else if (m == 1) exp_irq = (his[vi] >= his[ti]) ? 1 : 0;
          else             exp_irq = (his[vi] <  his[ti]) ? 1 : 0;
          if (m == 0)      chk("R2 R11 irq count", n_irq - i0, exp_irq);
          else if (m == 1) chk("R3 R11 irq count", n_irq - i0, exp_irq);
          else             chk("R4 R11 irq count", n_irq - i0, exp_irq);
          chk("R6 one start", n_start - s0, 1);
          chk("R6 start channel", log_ch[s0], ch);
          rd(ch, v);
          chk("R5 stored", v, val);
        end
      end
    end

    // R9 one-shot select stays idle
    s0 = n_start;
    wait_cyc(20);
    chk("R9 idle after one-shot", n_start - s0, 0);

    // R8 R9 R3 one-shot scan up to channel 5, threshold 96
    for (int c = 0; c < NCH; c++) eng_val[c] = 10'(c * 100 + 7);
    wr(2, 96);
    wr(1, 5);
    s0 = n_start; i0 = n_irq;
    wr(0, EN | SCAN | ONCE | CMP);
    wait_cyc(60);
    chk("R9 scan start count", n_start - s0, 6);
    exp_irq = 0;
    for (int c = 0; c < 6; c++) begin
      chk("R8 scan order", log_ch[s0 + c], c);
      if (((c * 100 + 7) >> 2) >= 96) exp_irq++;
      rd(c, v);
      chk("R5 scan stored", v, c * 100 + 7);
    end
    chk("R3 scan irq", n_irq - i0, exp_irq);

    // R7 R10 continuous select on channel 6
    eng_val[6] = 10'h3C1;
    wr(1, 6);
    s0 = n_start; i0 = n_irq;
    wr(0, EN);
    wait_cyc(40);
    wr(0, 0);
    ns = n_start - s0;
    wait_cyc(20);
    chk("R10 no start after abort", n_start - s0, ns);
    chk("R7 repeated", (ns >= 4) ? 1 : 0, 1);
    chk("R2 continuous irq", (n_irq - i0 >= ns - 1) ? 1 : 0, 1);
    for (int k = 0; k < ns; k++) begin
      chk("R7 channel", log_ch[s0 + k], 6);
      if (k > 0) chk("R7 gap", log_t[s0 + k] - log_t[s0 + k - 1], LAT + 2);
    end

    // R8 continuous scan wraps over channels 0..2
    wr(2, 0);
    wr(1, 2);
    s0 = n_start;
    wr(0, EN | SCAN | CMP);
    wait_cyc(50);
    wr(0, 0);
    ns = n_start - s0;
    wait_cyc(20);
    chk("R8 wrap count", (ns >= 7) ? 1 : 0, 1);
    for (int k = 0; k < ns; k++) begin
      chk("R8 wrap order", log_ch[s0 + k], k % 3);
      if (k > 0) chk("R8 gap", log_t[s0 + k] - log_t[s0 + k - 1], LAT + 2);
    end

    // R10 abort mid-conversion keeps the old result
    eng_val[3] = 10'h155;
    wr(1, 3);
    wr(0, EN | ONCE);
    wait_cyc(12);
    rd(3, v);
    chk("R5 preset", v, 10'h155);
    eng_val[3] = 10'h2AA;
    s0 = n_start; i0 = n_irq;
    wr(0, EN | ONCE);
    wait_cyc(1);
    wr(0, 0);
    wait_cyc(20);
    chk("R10 no irq", n_irq - i0, 0);
    chk("R10 one start", n_start - s0, 1);
    rd(3, v);
    chk("R10 result kept", v, 10'h155);
    i0 = n_irq;
    wr(0, EN | ONCE);
    wait_cyc(12);
    rd(3, v);
    chk("R6 restart stored", v, 10'h2AA);
    chk("R6 restart irq", n_irq - i0, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule